// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block is the digital front half of a two-channel 10-bit serial DAC. A host shifts 16-bit command words into it over a three-wire serial link made of an active-low select, a serial clock and a data line. The select, clock and data are resampled by the block's own system clock. When the select returns high after exactly one full word, the block decodes the 4-bit control code at the top of the word. That code decides whether a channel's input register is loaded, whether the DAC registers are refreshed from the input registers, and whether the part sleeps or wakes.

The two DAC register values leave the block as buses that feed the converters. A single enable flag tells the analog side whether to drive its outputs or hold them at high impedance. The input registers cannot be read directly; their contents show on the DAC buses only after an update command copies them across.

Top module: `dac_serial_decoder`

## Requirements
- R1: A command word is 16 bits sent most significant bit first, each bit captured on a rising edge of `spi_sck` while `spi_cs_n` is low. Bits 15:12 hold the control code, bits 11:2 hold the 10-bit data value, and bits 1:0 are ignored.
- R2: A word is acted on only when `spi_cs_n` rises after exactly 16 rising clock edges. A frame with fewer or more edges changes neither the DAC buses, nor `out_en`, nor either input register.
- R3: After reset both input registers and both DAC registers are zero, and the part is asleep (`out_en` = 0).
- R4: Code 0000 changes no register and leaves the sleep state as it is.
- R5: Code 0001 loads the data into input register A, and code 0010 loads it into input register B. Neither code touches the DAC registers or the sleep state.
- R6: Code 1000 copies both input registers into their DAC registers and wakes the part.
- R7: Code 1001 loads the data into input register A. It then loads DAC A from the new A value and DAC B from the existing B input register, and wakes the part.
- R8: Code 1010 loads the data into input register B. It then loads DAC B from the new B value and DAC A from the existing A input register, and wakes the part.
- R9: Codes 1100 and 1101 wake the part and leave every input and DAC register unchanged.
- R10: Code 1110 puts the part to sleep (`out_en` = 0) and leaves every register unchanged.
- R11: Code 1111 writes the same data value into both input registers and both DAC registers, and wakes the part.
- R12: Codes 0011, 0100, 0101, 0110, 0111 and 1011 have no effect on any register or on the sleep state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that resamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock; data is captured on its rising edge |
| spi_mosi | input | 1 | Serial command data, most significant bit first |
| dac_a | output | 10 | DAC register of channel A |
| dac_b | output | 10 | DAC register of channel B |
| out_en | output | 1 | 1 = outputs driven (awake), 0 = high impedance (asleep) |

## Verification
Each channel is loaded with different alternating-bit and all-ones values, so a swapped channel or a reversed bit order shows up as a wrong value on the bus. Load-only commands are followed by a global update that exposes the hidden input registers. This separates "loaded but not shown" from "never loaded". The reserved codes and the wrong-length frames carry data that differs from everything already stored, and a global update then proves that no input register moved. Sleep and both wake codes are cycled with nonzero DAC contents, so that losing the held values on sleep is told apart from simply dropping the enable.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      OP_NOP       = 4'b0000,
      OP_LD_A      = 4'b0001,
      OP_LD_B      = 4'b0010,
      OP_UPD_ALL   = 4'b1000,
      OP_LDUP_A    = 4'b1001,
      OP_LDUP_B    = 4'b1010,
      OP_WAKE_0    = 4'b1100,
      OP_WAKE_1    = 4'b1101,
      OP_SLEEP     = 4'b1110,
      OP_LDUP_BOTH = 4'b1111
   } dac_op_e;

   typedef struct packed {
      logic ld_a;
      logic ld_b;
      logic upd;
      logic wake;
      logic sleep;
   } dac_act_t;

   localparam dac_act_t ACT_NONE = '{ld_a: 1'b0, ld_b: 1'b0, upd: 1'b0,
                                     wake: 1'b0, sleep: 1'b0};

endpackage

// File: rtl/dac_sync_bit.sv
module dac_sync_bit #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("dac_sync_bit: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
   parameter int WORD_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n_i,
   input  logic                 sck_i,
   input  logic                 sdi_i,
   output logic                 word_vld_o,
   output logic [WORD_BITS-1:0] word_o
);

   localparam int CNT_MAX = WORD_BITS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (WORD_BITS < 2) begin : g_bad_len
         $error("dac_frame_rx: WORD_BITS too small");
      end
   endgenerate

   logic cs_s, sck_s, sdi_s;
   logic cs_q, sck_q;

   // One resampling chain per serial line; idle values differ per line
   localparam int  NLINES = 3;
   localparam logic [NLINES-1:0] IDLE_VAL = 3'b001;
   logic [NLINES-1:0] line_raw, line_sync;

   assign line_raw = {sdi_i, sck_i, cs_n_i};

   generate
      for (genvar li = 0; li < NLINES; li++) begin : g_sync
         dac_sync_bit #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_VAL[li])
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (line_raw[li]),
            .q_o   (line_sync[li])
         );
      end
   endgenerate

   assign cs_s  = line_sync[0];
   assign sck_s = line_sync[1];
   assign sdi_s = line_sync[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end

   logic sck_rise, cs_rise;
   assign sck_rise = sck_s & ~sck_q;
   assign cs_rise  = cs_s & ~cs_q;

   logic [CNT_W-1:0]     bit_cnt;
   logic [WORD_BITS-1:0] shift_q;

   // Edge counter saturates one past a full word so that long frames stay rejected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shift_q <= '0;
      end else if (cs_s) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         shift_q <= {shift_q[WORD_BITS-2:0], sdi_s};
         if (bit_cnt != CNT_W'(CNT_MAX)) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_vld_o <= 1'b0;
         word_o     <= '0;
      end else begin
         word_vld_o <= cs_rise && (bit_cnt == CNT_W'(WORD_BITS));
         if (cs_rise) begin
            word_o <= shift_q;
         end
      end
   end

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dacdec_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output dac_act_t          act_o
);

   always_comb begin
      act_o = ACT_NONE;
      case (code_i)
         OP_LD_A: begin
            act_o.ld_a = 1'b1;
         end
         OP_LD_B: begin
            act_o.ld_b = 1'b1;
         end
         OP_UPD_ALL: begin
            act_o.upd  = 1'b1;
            act_o.wake = 1'b1;
         end
         OP_LDUP_A: begin
            act_o.ld_a = 1'b1;
            act_o.upd  = 1'b1;
            act_o.wake = 1'b1;
         end
         OP_LDUP_B: begin
            act_o.ld_b = 1'b1;
            act_o.upd  = 1'b1;
            act_o.wake = 1'b1;
         end
         OP_WAKE_0, OP_WAKE_1: begin
            act_o.wake = 1'b1;
         end
         OP_SLEEP: begin
            act_o.sleep = 1'b1;
         end
         OP_LDUP_BOTH: begin
            act_o.ld_a = 1'b1;
            act_o.ld_b = 1'b1;
            act_o.upd  = 1'b1;
            act_o.wake = 1'b1;
         end
         default: begin
            act_o = ACT_NONE; // no-op and reserved codes
         end
      endcase
   end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
   import dacdec_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld_i,
   input  dac_act_t          act_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] dac_a_o,
   output logic [DATA_W-1:0] dac_b_o,
   output logic              awake_o
);

   logic [DATA_W-1:0] in_a_q, in_b_q;
   logic [DATA_W-1:0] in_a_nx, in_b_nx;

   // Input registers forward the new value so an update sees it in the same command
   always_comb begin
      in_a_nx = in_a_q;
      in_b_nx = in_b_q;
      if (cmd_vld_i && act_i.ld_a) in_a_nx = data_i;
      if (cmd_vld_i && act_i.ld_b) in_b_nx = data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_a_q  <= '0;
         in_b_q  <= '0;
         dac_a_o <= '0;
         dac_b_o <= '0;
         awake_o <= 1'b0;
      end else if (cmd_vld_i) begin
         in_a_q <= in_a_nx;
         in_b_q <= in_b_nx;
         if (act_i.upd) begin
            dac_a_o <= in_a_nx;
            dac_b_o <= in_b_nx;
         end
         if (act_i.sleep) begin
            awake_o <= 1'b0;
         end else if (act_i.wake) begin
            awake_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dac_serial_decoder.sv
module dac_serial_decoder
   import dacdec_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int WORD_BITS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b,
   output logic              out_en
);

   localparam int CODE_HI = WORD_BITS - 1;
   localparam int DATA_HI = WORD_BITS - CODE_W - 1;

   generate
      if (WORD_BITS < CODE_W + DATA_W) begin : g_bad_word
         $error("dac_serial_decoder: word too short for code and data");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dac_serial_decoder: DATA_W must be positive");
      end
   endgenerate

   logic                 word_vld;
   logic [WORD_BITS-1:0] word;
   logic [CODE_W-1:0]    code;
   logic [DATA_W-1:0]    data;
   dac_act_t             act;

   dac_frame_rx #(
      .WORD_BITS   (WORD_BITS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_i     (spi_cs_n),
      .sck_i      (spi_sck),
      .sdi_i      (spi_mosi),
      .word_vld_o (word_vld),
      .word_o     (word)
   );

   assign code = word[CODE_HI -: CODE_W];
   assign data = word[DATA_HI -: DATA_W];

   dac_cmd_decode u_dec (
      .code_i (code),
      .act_o  (act)
   );

   dac_reg_bank #(
      .DATA_W (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_vld_i (word_vld),
      .act_i     (act),
      .data_i    (data),
      .dac_a_o   (dac_a),
      .dac_b_o   (dac_b),
      .awake_o   (out_en)
   );

endmodule

// File: rtl/dac_serial_decoder_chk.sv
module dac_serial_decoder_chk #(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_vld,
   input logic [3:0]        code,
   input logic [DATA_W-1:0] data,
   input logic [DATA_W-1:0] dac_a,
   input logic [DATA_W-1:0] dac_b,
   input logic              out_en
);

   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> $stable(dac_a) && $stable(dac_b) && $stable(out_en));

   a_r4_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b0000 |=> $stable(dac_a) && $stable(dac_b) && $stable(out_en));

   a_r5_load_only: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && (code == 4'b0001 || code == 4'b0010)
      |=> $stable(dac_a) && $stable(dac_b) && $stable(out_en));

   a_r6_update_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b1000 |=> out_en);

   a_r7_load_up_a: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b1001 |=> dac_a == $past(data) && out_en);

   a_r8_load_up_b: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b1010 |=> dac_b == $past(data) && out_en);

   a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && (code == 4'b1100 || code == 4'b1101)
      |=> out_en && $stable(dac_a) && $stable(dac_b));

   a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b1110 |=> !out_en && $stable(dac_a) && $stable(dac_b));

   a_r11_both_same: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && code == 4'b1111
      |=> dac_a == $past(data) && dac_b == $past(data) && out_en);

   a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld && (code == 4'b0011 || code == 4'b0100 || code == 4'b0101 ||
                   code == 4'b0110 || code == 4'b0111 || code == 4'b1011)
      |=> $stable(dac_a) && $stable(dac_b) && $stable(out_en));

endmodule

bind dac_serial_decoder dac_serial_decoder_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .word_vld (word_vld),
   .code     (code),
   .data     (data),
   .dac_a    (dac_a),
   .dac_b    (dac_b),
   .out_en   (out_en)
);

// File: tb/sim_dac_serial_decoder.sv
module sim_dac_serial_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_sck = 1'b0;
   logic       spi_mosi = 1'b0;
   logic [9:0] dac_a, dac_b;
   logic       out_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // model state
   logic [9:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;
   logic       m_en = 1'b0;

   always #2 clk = ~clk;

   dac_serial_decoder u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_cs_n (spi_cs_n),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi),
      .dac_a    (dac_a),
      .dac_b    (dac_b),
      .out_en   (out_en)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req);
      n_chk++;
      if (dac_a !== m_dac_a || dac_b !== m_dac_b || out_en !== m_en) begin
         n_bad++;
         $display("FAIL %s: got a=%h b=%h en=%b expected a=%h b=%h en=%b",
                  req, dac_a, dac_b, out_en, m_dac_a, m_dac_b, m_en);
      end
   endtask

   task automatic send_frame(input int nbits, input logic [15:0] w);
      spi_cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 16) ? w[15-i] : 1'b0;
         wait_clk(3);
         spi_sck = 1'b1;
         wait_clk(4);
         spi_sck = 1'b0;
         wait_clk(1);
      end
      wait_clk(4);
      spi_cs_n = 1'b1;
      wait_clk(12);
   endtask

   // send a full word and advance the model according to the requirements
   task automatic cmd(input logic [3:0] code, input logic [9:0] d, input logic [1:0] pad);
      send_frame(16, {code, d, pad});
      case (code)
         4'b0001: m_in_a = d;
         4'b0010: m_in_b = d;
         4'b1000: begin m_dac_a = m_in_a; m_dac_b = m_in_b; m_en = 1'b1; end
         4'b1001: begin m_in_a = d; m_dac_a = m_in_a; m_dac_b = m_in_b; m_en = 1'b1; end
         4'b1010: begin m_in_b = d; m_dac_a = m_in_a; m_dac_b = m_in_b; m_en = 1'b1; end
         4'b1100, 4'b1101: m_en = 1'b1;
         4'b1110: m_en = 1'b0;
         4'b1111: begin m_in_a = d; m_in_b = d; m_dac_a = d; m_dac_b = d; m_en = 1'b1; end
         default: ;
      endcase
   endtask

   task automatic t_reset();
      check("R3 reset state");
   endtask

   task automatic t_load_only();
      cmd(4'b0001, 10'h155, 2'b00);
      check("R5 load A only");
      cmd(4'b0010, 10'h2AA, 2'b00);
      check("R5 load B only");
      cmd(4'b1000, 10'h000, 2'b00);
      check("R6 update both from inputs");
   endtask

   task automatic t_nop();
      cmd(4'b0000, 10'h3FF, 2'b11);
      check("R4 no-op");
      cmd(4'b1000, 10'h000, 2'b00);
      check("R4 no-op left inputs");
   endtask

   task automatic t_load_update();
      cmd(4'b1001, 10'h3FF, 2'b00);
      check("R7 load A with update, MSB first R1");
      cmd(4'b1010, 10'h001, 2'b00);
      check("R8 load B with update");
      cmd(4'b1001, 10'h200, 2'b11);
      check("R1 pad bits ignored R7");
   endtask

   task automatic t_sleep_wake();
      cmd(4'b1110, 10'h0F0, 2'b00);
      check("R10 sleep holds registers");
      cmd(4'b1100, 10'h0F0, 2'b00);
      check("R9 wake code 1100");
      cmd(4'b1110, 10'h000, 2'b00);
      check("R10 sleep again");
      cmd(4'b1101, 10'h111, 2'b00);
      check("R9 wake code 1101");
   endtask

   task automatic t_both();
      cmd(4'b1110, 10'h000, 2'b00);
      cmd(4'b1111, 10'h0F0, 2'b01);
      check("R11 shared code wakes and loads");
   endtask

   task automatic t_reserved();
      logic [3:0] rsv [6] = '{4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1011};
      cmd(4'b1110, 10'h000, 2'b00);
      for (int k = 0; k < 6; k++) begin
         cmd(rsv[k], 10'h3C3, 2'b10);
         check($sformatf("R12 reserved code %b", rsv[k]));
      end
      cmd(4'b1000, 10'h000, 2'b00);
      check("R12 reserved left inputs");
   endtask

   task automatic t_bad_len();
      send_frame(15, {4'b1111, 10'h2B5, 2'b00});
      check("R2 short frame ignored");
      send_frame(17, {4'b1111, 10'h2B5, 2'b00});
      check("R2 long frame ignored");
      send_frame(16, {4'b0001, 10'h1E1, 2'b00}); // valid load to expose later
      m_in_a = 10'h1E1;
      send_frame(12, {4'b0001, 10'h3AB, 2'b00});
      cmd(4'b1000, 10'h000, 2'b00);
      check("R2 short frame left input A");
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_load_only();
      t_nop();
      t_load_update();
      t_sleep_wake();
      t_both();
      t_reserved();
      t_bad_len();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule